// File: doc/BRIEF.md
# Binary/BCD Presettable Down Counter

This block is the counting element inside a single channel of an interval timer. It holds a 16-bit value that steps down by one on each qualified clock enable. The step uses either plain binary arithmetic or four packed decimal digits, and a mode input chosen by the channel's control setting selects which.

The only way to preset the counter is a parallel transfer from the channel's count register. Both bytes arrive in the same cycle. The bus has no path to write or read the counter itself. Its value is exposed continuously so that the channel's output latch can follow it.

Two flags report when the current value equals zero and when it equals one. The channel's mode sequencing uses these flags to decide when its output changes.

Top module: `bcd_down_counter`

## Requirements
- R1: After reset the count is 0x0000, the zero flag is high and the one flag is low.
- R2: When the load strobe is high at a rising clock edge, the whole 16-bit preset value appears on the count output after that edge, with both bytes updated together.
- R3: A load and a count enable in the same cycle give the preset value, not a decremented value.
- R4: In binary mode (mode input low), a count enable without a load lowers the count by one.
- R5: In binary mode, a decrement from 0x0000 gives 0xFFFF.
- R6: In BCD mode (mode input high), the count is four decimal digits packed 4 bits each, with the most significant digit in bits 15:12. A decrement lowers the value by one decimal unit. A digit at 0 becomes 9 and borrows from the next higher digit, so 0x1000 becomes 0x0999 and 0x0010 becomes 0x0009.
- R7: In BCD mode, a decrement from 0x0000 gives 0x9999.
- R8: When neither the load strobe nor the count enable is high, the count keeps its value in both modes.
- R9: The zero flag is high exactly when the count is 0x0000. The one flag is high exactly when the count is 0x0001. Both follow the current count with no added register, and they are never high together.
- R10: The mode input is applied at each decrement, so the same stored value steps differently depending on the mode. For example, 0x0010 becomes 0x000F in binary mode and 0x0009 in BCD mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Parallel preset strobe from the count register |
| load_val | input | 16 | Preset value from the count register |
| cnt_en | input | 1 | Qualified decrement enable |
| bcd_mode | input | 1 | 1: four-digit BCD counting, 0: binary counting |
| count | output | 16 | Current counter value, fed to the output latch |
| at_zero | output | 1 | High when the count is 0x0000 |
| at_one | output | 1 | High when the count is 0x0001 |

## Verification
The bench works through the wrap points of both arithmetic modes and the digit borrow chains that cross one or more zero digits. A binary wrap that stuck at zero, or a BCD borrow that left a digit at F instead of 9, would show up as a wrong count on the very next cycle. It asserts load and enable together, which exposes a design that gives the decrement priority over the preset. It also loads one value and steps it under each mode, which catches a mode input that is latched or ignored.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned DIGIT_W = 4;

  // Plain binary step, wraps through all ones.
  function automatic logic [CNT_W-1:0] bin_step(input logic [CNT_W-1:0] v);
    return v - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  // True when v equals the small constant k.
  function automatic logic value_is(input logic [CNT_W-1:0] v, input int unsigned k);
    return (v == CNT_W'(k));
  endfunction
endpackage

// File: rtl/dcnt_digit.sv
module dcnt_digit #(
  parameter int unsigned DW = 4
) (
  input  logic [DW-1:0] d_in,
  input  logic          borrow_in,
  output logic [DW-1:0] d_out,
  output logic          borrow_out
);
  localparam logic [DW-1:0] NINE = DW'(9);

  // One decimal digit: a zero under borrow becomes nine and passes it on.
  always_comb begin
    if (!borrow_in) begin
      d_out      = d_in;
      borrow_out = 1'b0;
    end else if (d_in == '0) begin
      d_out      = NINE;
      borrow_out = 1'b1;
    end else begin
      d_out      = d_in - DW'(1);
      borrow_out = 1'b0;
    end
  end
endmodule

// File: rtl/dcnt_next.sv
module dcnt_next #(
  parameter int unsigned W  = dcnt_pkg::CNT_W,
  parameter int unsigned DW = dcnt_pkg::DIGIT_W
) (
  input  logic [W-1:0] cur,
  input  logic         bcd_mode,
  output logic [W-1:0] nxt,
  output logic         dec_wrap
);
  localparam int unsigned DIGITS = W / DW;

  logic [DIGITS:0] borrow;
  logic [W-1:0]    bcd_val;

  assign borrow[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    dcnt_digit #(.DW(DW)) u_digit (
      .d_in      (cur[g*DW +: DW]),
      .borrow_in (borrow[g]),
      .d_out     (bcd_val[g*DW +: DW]),
      .borrow_out(borrow[g+1])
    );
  end

  always_comb begin
    if (bcd_mode) nxt = bcd_val;
    else          nxt = dcnt_pkg::bin_step(cur);
  end

  // A borrow out of the top digit means the value ran through zero.
  assign dec_wrap = borrow[DIGITS];
endmodule

// File: rtl/bcd_down_counter.sv
module bcd_down_counter #(
  parameter int unsigned W  = dcnt_pkg::CNT_W,
  parameter int unsigned DW = dcnt_pkg::DIGIT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         cnt_en,
  input  logic         bcd_mode,
  output logic [W-1:0] count,
  output logic         at_zero,
  output logic         at_one
);
  localparam logic [W-1:0] ALL_NINES = {(W/DW){DW'(9)}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] step_val;
  logic         wrap_evt;
  logic         load_fire;
  logic         dec_fire;

  dcnt_next #(.W(W), .DW(DW)) u_next (
    .cur     (cnt_q),
    .bcd_mode(bcd_mode),
    .nxt     (step_val),
    .dec_wrap(wrap_evt)
  );

  assign load_fire = load_en;
  assign dec_fire  = cnt_en && !load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (load_fire) cnt_q <= load_val;
    else if (dec_fire)  cnt_q <= step_val;
  end

  assign count   = cnt_q;
  assign at_zero = dcnt_pkg::value_is(cnt_q, 0);
  assign at_one  = dcnt_pkg::value_is(cnt_q, 1);

  // R2, R3: a preset wins and lands whole on the next edge
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (count == $past(load_val)));

  // R8
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !cnt_en) |=> $stable(count));

  // R5
  p_bin_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_fire && !bcd_mode && at_zero) |=> (count == '1));

  // R7
  p_bcd_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_fire && bcd_mode && at_zero) |=> (count == ALL_NINES));

  // R6: a BCD wrap event only happens from zero
  p_wrap_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bcd_mode && wrap_evt) |-> at_zero);

  // R9
  p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({at_zero, at_one}));
endmodule

// File: tb/bcd_down_counter_tb.sv
`timescale 1ns/1ps
module bcd_down_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [15:0] load_val = '0;
  logic        cnt_en = 1'b0;
  logic        bcd_mode = 1'b0;
  logic [15:0] count;
  logic        at_zero;
  logic        at_one;

  int checks = 0;
  int fails  = 0;

  logic [15:0] q_val[$];
  string       q_tag[$];
  logic [15:0] model = '0;

  always #4 clk = ~clk;

  bcd_down_counter u_dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
    .cnt_en(cnt_en), .bcd_mode(bcd_mode), .count(count),
    .at_zero(at_zero), .at_one(at_one)
  );

  function automatic int to_dec(input logic [15:0] b);
    return b[15:12]*1000 + b[11:8]*100 + b[7:4]*10 + b[3:0];
  endfunction

  function automatic logic [15:0] to_bcd(input int n);
    logic [15:0] r;
    r[15:12] = 4'((n / 1000) % 10);
    r[11:8]  = 4'((n / 100) % 10);
    r[7:4]   = 4'((n / 10) % 10);
    r[3:0]   = 4'(n % 10);
    return r;
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    checks++;
    if (count !== exp) begin
      fails++;
      $display("FAIL %s count: actual %h expected %h", tag, count, exp);
    end
    checks++;
    if (at_zero !== (exp == 16'h0) || at_one !== (exp == 16'h1)) begin
      fails++;
      $display("FAIL R9 (%s) flags zero/one: actual %b%b expected %b%b",
               tag, at_zero, at_one, exp == 16'h0, exp == 16'h1);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input logic ld, input logic [15:0] v, input logic en,
                      input logic bcd, input string tag);
    if (ld)      model = v;
    else if (en) model = bcd ? to_bcd((to_dec(model) + 9999) % 10000) : model - 16'd1;
    load_en = ld; load_val = v; cnt_en = en; bcd_mode = bcd;
    q_val.push_back(model);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: compares shortly after each edge.
  always @(posedge clk) begin
    #2;
    if (q_val.size() > 0) check(q_tag.pop_front(), q_val.pop_front());
  end

  initial begin
    #80000;
    fails++;
    $display("FAIL watchdog expired (all requirements)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    // binary
    step(1, 16'h1234, 0, 0, "R2");
    step(0, 16'h0000, 1, 0, "R4");
    step(0, 16'h0000, 0, 0, "R8");
    step(0, 16'h0000, 0, 0, "R8");
    step(1, 16'h0001, 0, 0, "R9");
    step(0, 16'h0000, 1, 0, "R9");
    step(0, 16'h0000, 1, 0, "R5");
    step(0, 16'h0000, 1, 0, "R4");
    step(1, 16'h00FF, 1, 0, "R3");
    step(1, 16'h0100, 0, 0, "R2");
    step(0, 16'h0000, 1, 0, "R4");
    // BCD
    step(1, 16'h1000, 0, 1, "R2");
    step(0, 16'h0000, 1, 1, "R6");
    step(0, 16'h0000, 1, 1, "R6");
    step(0, 16'h0000, 0, 1, "R8");
    step(1, 16'h0010, 0, 1, "R2");
    step(0, 16'h0000, 1, 1, "R6");
    step(1, 16'h0000, 0, 1, "R2");
    step(0, 16'h0000, 1, 1, "R7");
    step(0, 16'h0000, 1, 1, "R6");
    step(1, 16'h0100, 1, 1, "R3");
    step(1, 16'h0002, 0, 1, "R2");
    step(0, 16'h0000, 1, 1, "R9");
    step(0, 16'h0000, 1, 1, "R9");
    // mode applied per decrement
    step(1, 16'h0010, 0, 0, "R2");
    step(0, 16'h0000, 1, 0, "R10");
    step(1, 16'h0010, 0, 1, "R2");
    step(0, 16'h0000, 1, 1, "R10");
    step(0, 16'h0000, 0, 0, "R8");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule